// File: doc/BRIEF.md
# Strided Vector Load Unit over Interleaved Memory Banks

This block is the load side of a vector memory path. A single start pulse hands it a base word address, a stride and an element count. The block then walks the element addresses one per cycle. It sends each address to one of sixteen word-interleaved banks of 64-bit words. Each read word comes back on a write-port interface for the vector register file, and each word carries the index of the element it belongs to.

Each bank can take a new request only every few cycles. When a request targets a bank that is still recovering, the address walker holds that element until the bank frees up, and it never lets a later element go ahead. A unit stride visits all sixteen banks in turn and so runs at one element per cycle. A stride that keeps landing on the same bank runs at the bank recovery rate.

A separate fill port writes single words straight into the banks. It is used to place the data that the loads will read.

Top module: `vmem_strided_load`

## Requirements
- R1: There are 16 banks of 64-bit words. For word address A, the bank is A[3:0] and the row inside that bank is A[9:4]. Each returned word is the word stored at its element address.
- R2: Element i reads word address (base_addr + i * stride) mod 1024. The stride is taken as a 10-bit two's-complement value, so 1023 means -1.
- R3: At most one element request is accepted per cycle, and requests are accepted in element order. Elements that fall in distinct free banks are accepted in back-to-back cycles.
- R4: A bank that accepts a request in cycle t cannot accept another before cycle t+4. An element whose bank is busy stalls all later elements until that bank accepts it.
- R5: The word for an element accepted in cycle t appears on wb_valid/wb_data in cycle t+12. Returns come in element order, and wb_idx gives the element index.
- R6: busy is high from the cycle after an accepted start through the cycle of the last return. done pulses for one cycle in the cycle after the last return, and busy is low in that cycle.
- R7: When vec_len is 0, done pulses in the cycle after start, no word is returned and busy stays low.
- R8: A start pulse that arrives while busy is high is ignored. The running operation and its results are unaffected, and nothing extra is returned.
- R9: A fill write (fill_en high) stores fill_data at fill_addr at the clock edge. Requests accepted in later cycles read the new value.
- R10: After reset, busy, done and wb_valid are low.
- R11: A vec_len above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load operation (taken only when idle) |
| base_addr | input | 10 | Word address of element 0 |
| stride | input | 10 | Word distance between elements, two's complement |
| vec_len | input | 7 | Number of elements (clamped to 64) |
| fill_en | input | 1 | Write one word into the banks |
| fill_addr | input | 10 | Word address for the fill write |
| fill_data | input | 64 | Data for the fill write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Returned word valid |
| wb_idx | output | 6 | Element index of the returned word |
| wb_data | output | 64 | Returned word |

## Verification
The bench predicts the acceptance cycle of every element with its own bank-occupancy model and then checks the return cycle, index and data of each word. The stride patterns are chosen to separate the timing behaviours. A stride of 16 or 32 hits one bank every time: if the design ignores bank recovery, the words come back too early, and if it applies the recovery to the wrong bank, it stalls a unit-stride stream. A stride of 8 alternates between two banks. A negative stride and an address run past the top of memory both catch wrong modulo arithmetic, which would return the wrong words. The remaining cases are a zero length, a single element, an oversized length, a start pulse during a run and a fill just before a read. These expose a design that hangs, sends spurious returns, lets a late start overwrite the running operation, or returns stale data.

// File: rtl/vmem_pkg.sv
package vmem_pkg;

  // Word address of one element: base + idx * stride, truncated by the caller.
  function automatic int unsigned strided_addr(input int unsigned base,
                                               input int unsigned stride,
                                               input int unsigned idx);
    return base + idx * stride;
  endfunction

  // Interleaving: consecutive words go to consecutive banks.
  function automatic int unsigned bank_sel(input int unsigned waddr,
                                           input int unsigned nbanks);
    return waddr % nbanks;
  endfunction

  function automatic int unsigned row_sel(input int unsigned waddr,
                                          input int unsigned nbanks);
    return waddr / nbanks;
  endfunction

  function automatic int unsigned clamp_len(input int unsigned req,
                                            input int unsigned cap);
    return (req > cap) ? cap : req;
  endfunction

endpackage

// File: rtl/vmem_agu.sv
module vmem_agu #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LEN_W  = 7,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              ready_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [IDX_W-1:0]  req_idx_o,
  output logic              req_last_o,
  output logic [ADDR_W-1:0] base_q_o,
  output logic [ADDR_W-1:0] stride_q_o
);
  logic              issuing_q;
  logic [LEN_W-1:0]  cnt_q, len_q;
  logic [ADDR_W-1:0] addr_q, base_q, stride_q;

  // Incremental walk: one add per element instead of a multiplier.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issuing_q <= 1'b0;
      cnt_q     <= '0;
      len_q     <= '0;
      addr_q    <= '0;
      base_q    <= '0;
      stride_q  <= '0;
    end else if (start_i) begin
      issuing_q <= (len_i != '0);
      cnt_q     <= '0;
      len_q     <= len_i;
      addr_q    <= base_i;
      base_q    <= base_i;
      stride_q  <= stride_i;
    end else if (issuing_q && ready_i) begin
      cnt_q  <= cnt_q + LEN_W'(1);
      addr_q <= addr_q + stride_q;
      if (cnt_q == len_q - LEN_W'(1)) issuing_q <= 1'b0;
    end
  end

  assign req_valid_o = issuing_q;
  assign req_addr_o  = addr_q;
  assign req_idx_o   = cnt_q[IDX_W-1:0];
  assign req_last_o  = (cnt_q == len_q - LEN_W'(1));
  assign base_q_o    = base_q;
  assign stride_q_o  = stride_q;
endmodule

// File: rtl/vmem_bank.sv
module vmem_bank #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned ROW_W    = 6,
  parameter int unsigned BUSY_CYC = 4,
  localparam int unsigned ROWS    = 1 << ROW_W,
  localparam int unsigned CNT_W   = $clog2(BUSY_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              fill_we_i,
  input  logic [ROW_W-1:0]  fill_row_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic              free_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [ROWS];
  logic [CNT_W-1:0]  rest_q;
  logic [DATA_W-1:0] rd_q;

  // Recovery counter: loaded on accept, bank free again when it reaches zero.
  always_ff @(posedge clk) begin
    if (!rst_n)            rest_q <= '0;
    else if (acc_i)        rest_q <= CNT_W'(BUSY_CYC - 1);
    else if (rest_q != '0) rest_q <= rest_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (fill_we_i) mem_q[fill_row_i] <= fill_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (acc_i) rd_q <= mem_q[row_i];
  end

  assign free_o    = (rest_q == '0);
  assign rd_data_o = rd_q;
endmodule

// File: rtl/vmem_ret_pipe.sv
module vmem_ret_pipe #(
  parameter int unsigned NUM_BANKS = 16,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned IDX_W     = 6,
  parameter int unsigned LATENCY   = 12,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid_i,
  input  logic [IDX_W-1:0]                 in_idx_i,
  input  logic                             in_last_i,
  input  logic [BANK_W-1:0]                in_bank_i,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_data_i,
  output logic                             out_valid_o,
  output logic [IDX_W-1:0]                 out_idx_o,
  output logic                             out_last_o,
  output logic [DATA_W-1:0]                out_data_o
);
  logic [LATENCY-1:0] v_q, last_q;
  logic [IDX_W-1:0]   idx_q  [LATENCY];
  logic [DATA_W-1:0]  data_q [LATENCY];
  logic [BANK_W-1:0]  bank0_q;

  // Stage 0 holds the accepted request; the bank read word joins at stage 1.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q[0]    <= 1'b0;
      last_q[0] <= 1'b0;
      idx_q[0]  <= '0;
      data_q[0] <= '0;
      bank0_q   <= '0;
    end else begin
      v_q[0]    <= in_valid_i;
      last_q[0] <= in_valid_i && in_last_i;
      idx_q[0]  <= in_idx_i;
      data_q[0] <= '0;
      bank0_q   <= in_bank_i;
    end
  end

  for (genvar k = 1; k < LATENCY; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[k]    <= 1'b0;
        last_q[k] <= 1'b0;
        idx_q[k]  <= '0;
        data_q[k] <= '0;
      end else begin
        v_q[k]    <= v_q[k-1];
        last_q[k] <= last_q[k-1];
        idx_q[k]  <= idx_q[k-1];
        if (k == 1) data_q[k] <= bank_data_i[bank0_q];
        else        data_q[k] <= data_q[k-1];
      end
    end
  end

  assign out_valid_o = v_q[LATENCY-1];
  assign out_last_o  = last_q[LATENCY-1];
  assign out_idx_o   = idx_q[LATENCY-1];
  assign out_data_o  = data_q[LATENCY-1];
endmodule

// File: rtl/vmem_strided_load.sv
module vmem_strided_load
  import vmem_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 16,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned BUSY_CYC  = 4,
  parameter int unsigned LATENCY   = 12,
  parameter int unsigned MAX_VL    = 64,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
  localparam int unsigned ROW_W    = ADDR_W - BANK_W,
  localparam int unsigned IDX_W    = $clog2(MAX_VL),
  localparam int unsigned LEN_W    = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LEN_W-1:0]  vec_len,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              busy,
  output logic              done,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data
);
  logic                             busy_q, done_q, start_go;
  logic [LEN_W-1:0]                 len_eff;
  logic                             req_valid, req_last, req_ready, req_accept;
  logic [ADDR_W-1:0]                req_addr, agu_base_q, agu_stride_q;
  logic [IDX_W-1:0]                 req_idx;
  logic [BANK_W-1:0]                req_bank, fill_bank;
  logic [ROW_W-1:0]                 req_row, fill_row;
  logic [NUM_BANKS-1:0]             bank_free, acc_vec, fill_vec;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd;
  logic                             ret_valid, ret_last;

  assign start_go = start && !busy_q;
  assign len_eff  = LEN_W'(clamp_len(int'(vec_len), MAX_VL));

  vmem_agu #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_agu (
    .clk(clk), .rst_n(rst_n), .start_i(start_go), .base_i(base_addr),
    .stride_i(stride), .len_i(len_eff), .ready_i(req_ready),
    .req_valid_o(req_valid), .req_addr_o(req_addr), .req_idx_o(req_idx),
    .req_last_o(req_last), .base_q_o(agu_base_q), .stride_q_o(agu_stride_q)
  );

  assign req_bank   = BANK_W'(bank_sel(int'(req_addr), NUM_BANKS));
  assign req_row    = ROW_W'(row_sel(int'(req_addr), NUM_BANKS));
  assign fill_bank  = BANK_W'(bank_sel(int'(fill_addr), NUM_BANKS));
  assign fill_row   = ROW_W'(row_sel(int'(fill_addr), NUM_BANKS));
  assign req_ready  = bank_free[req_bank];
  assign req_accept = req_valid && req_ready;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign acc_vec[b]  = req_accept && (req_bank == BANK_W'(b));
    assign fill_vec[b] = fill_en && (fill_bank == BANK_W'(b));
    vmem_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W), .BUSY_CYC(BUSY_CYC)) u_bank (
      .clk(clk), .rst_n(rst_n), .acc_i(acc_vec[b]), .row_i(req_row),
      .fill_we_i(fill_vec[b]), .fill_row_i(fill_row), .fill_data_i(fill_data),
      .free_o(bank_free[b]), .rd_data_o(bank_rd[b])
    );
  end

  vmem_ret_pipe #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .IDX_W(IDX_W),
                  .LATENCY(LATENCY)) u_ret (
    .clk(clk), .rst_n(rst_n), .in_valid_i(req_accept), .in_idx_i(req_idx),
    .in_last_i(req_last), .in_bank_i(req_bank), .bank_data_i(bank_rd),
    .out_valid_o(ret_valid), .out_idx_o(wb_idx), .out_last_o(ret_last),
    .out_data_o(wb_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= (start_go && len_eff == '0) || (ret_valid && ret_last);
      if (start_go && len_eff != '0)  busy_q <= 1'b1;
      else if (ret_valid && ret_last) busy_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign wb_valid = ret_valid;
endmodule

// File: rtl/vmem_strided_load_chk.sv
module vmem_strided_load_chk
  import vmem_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 16,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned BUSY_CYC  = 4,
  parameter int unsigned LATENCY   = 12,
  parameter int unsigned IDX_W     = 6,
  localparam int unsigned CW       = $clog2(BUSY_CYC + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 start_go,
  input logic                 busy,
  input logic                 done,
  input logic                 req_valid,
  input logic [ADDR_W-1:0]    req_addr,
  input logic [IDX_W-1:0]     req_idx,
  input logic [ADDR_W-1:0]    base_q,
  input logic [ADDR_W-1:0]    stride_q,
  input logic [NUM_BANKS-1:0] acc_vec,
  input logic                 wb_valid,
  input logic [IDX_W-1:0]     wb_idx
);
  logic [LATENCY-1:0] acc_hist;
  logic [IDX_W:0]     next_ret;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_hist <= '0;
    else        acc_hist <= {acc_hist[LATENCY-2:0], |acc_vec};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        next_ret <= '0;
    else if (start_go) next_ret <= '0;
    else if (wb_valid) next_ret <= next_ret + 1'b1;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_rest
    logic [CW-1:0] rest;
    always_ff @(posedge clk) begin
      if (!rst_n)          rest <= '0;
      else if (acc_vec[b]) rest <= CW'(BUSY_CYC - 1);
      else if (rest != '0) rest <= rest - CW'(1);
    end
    // R4
    bank_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vec[b] |-> rest == '0);
  end

  // R3
  one_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_vec));

  // R2
  elem_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr == ADDR_W'(strided_addr(int'(base_q), int'(stride_q), int'(req_idx))));

  // R5
  ret_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid == acc_hist[LATENCY-1]);

  // R5
  ret_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> {1'b0, wb_idx} == next_ret);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(base_q) && $stable(stride_q));
endmodule

bind vmem_strided_load vmem_strided_load_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC),
  .LATENCY(LATENCY), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_go(start_go), .busy(busy),
  .done(done), .req_valid(req_valid), .req_addr(req_addr), .req_idx(req_idx),
  .base_q(agu_base_q), .stride_q(agu_stride_q), .acc_vec(acc_vec),
  .wb_valid(wb_valid), .wb_idx(wb_idx)
);

// File: tb/vmem_strided_load_test.sv
module vmem_strided_load_test;
  localparam int AW = 10, LAT = 12, BUSY_T = 4, MAXVL = 64;

  logic        clk = 1'b0;
  logic        rst_n, start, fill_en;
  logic [9:0]  base_addr, stride_i, fill_addr;
  logic [6:0]  vec_len;
  logic [63:0] fill_data;
  logic        busy, done, wb_valid;
  logic [5:0]  wb_idx;
  logic [63:0] wb_data;

  always #5 clk = ~clk;

  vmem_strided_load uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .stride(stride_i), .vec_len(vec_len), .fill_en(fill_en),
    .fill_addr(fill_addr), .fill_data(fill_data), .busy(busy), .done(done),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, fails = 0;
  bit mon_on = 1'b0;
  logic [63:0] model [1024];
  int bank_free_at [16];
  int          q_idx [$];
  logic [63:0] q_data [$];
  int          q_cyc [$];
  string       q_tag [$];

  function automatic logic [63:0] pattern(input int a);
    return {32'(a) * 32'h9E3779B1, 32'hC0DE0000 | 32'(a)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: compare each return against the front of the scoreboard.
  always @(negedge clk) begin
    if (mon_on && wb_valid) begin
      if (q_idx.size() == 0) begin
        chk(1'b0, "R5 R8", "return with nothing expected", 64'(wb_idx), 64'hFFFF);
      end else begin
        int ei, ec;
        logic [63:0] ed;
        string tg;
        ei = q_idx.pop_front();
        ed = q_data.pop_front();
        ec = q_cyc.pop_front();
        tg = q_tag.pop_front();
        chk(wb_idx == 6'(ei), "R5", {tg, " element index"}, 64'(wb_idx), 64'(ei));
        chk(wb_data == ed, "R1 R2", {tg, " data"}, wb_data, ed);
        chk(cyc == ec, "R3 R4 R5", {tg, " return cycle"}, 64'(cyc), 64'(ec));
      end
    end
  end

  // Driver: start one operation, predict every acceptance cycle, wait for done.
  task automatic run_op(input int base, input int strd, input int vl,
                        input string tag, input int poke);
    int n, k, t, acc_last, exp_done, waited;
    n = (vl > MAXVL) ? MAXVL : vl;
    @(negedge clk);
    base_addr = 10'(base);
    stride_i  = 10'(strd);
    vec_len   = 7'(vl);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = cyc;
    chk(busy == (n != 0), "R6", {tag, " busy after start"}, 64'(busy), 64'(n != 0));
    t = k;
    acc_last = k;
    for (int i = 0; i < n; i++) begin
      int a, b;
      a = (base + i * strd) & 1023;
      b = a & 15;
      if (t < bank_free_at[b]) t = bank_free_at[b];
      q_idx.push_back(i);
      q_data.push_back(model[a]);
      q_cyc.push_back(t + LAT);
      q_tag.push_back(tag);
      bank_free_at[b] = t + BUSY_T;
      acc_last = t;
      t++;
    end
    exp_done = (n == 0) ? k : acc_last + LAT + 1;
    waited = 0;
    while (!done && waited < 400) begin
      if (poke > 0 && waited == poke) begin
        base_addr = 10'd7; stride_i = 10'd5; vec_len = 7'd3; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    chk(done == 1'b1 && cyc == exp_done, "R6", {tag, " done cycle"}, 64'(cyc), 64'(exp_done));
    chk(busy == 1'b0, "R6", {tag, " busy low with done"}, 64'(busy), 64'd0);
    chk(q_idx.size() == 0, "R5", {tag, " returns missing"}, 64'(q_idx.size()), 64'd0);
    @(negedge clk);
    chk(done == 1'b0, "R6", {tag, " done is one cycle"}, 64'(done), 64'd0);
    repeat (2) @(negedge clk);
  endtask

  task automatic fill_word(input int a, input logic [63:0] d);
    fill_en = 1'b1; fill_addr = 10'(a); fill_data = d; model[a] = d;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #(150000 * 10);
    total++; fails++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; fill_en = 1'b0;
    base_addr = '0; stride_i = '0; vec_len = '0; fill_addr = '0; fill_data = '0;
    for (int b = 0; b < 16; b++) bank_free_at[b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(busy == 1'b0, "R10", "busy after reset", 64'(busy), 64'd0);
    chk(done == 1'b0, "R10", "done after reset", 64'(done), 64'd0);
    chk(wb_valid == 1'b0, "R10", "wb_valid after reset", 64'(wb_valid), 64'd0);
    mon_on = 1'b1;

    fill_en = 1'b1;
    for (int a = 0; a < 1024; a++) begin
      fill_addr = 10'(a); fill_data = pattern(a); model[a] = pattern(a);
      @(negedge clk);
    end
    fill_en = 1'b0;

    run_op(0, 1, 64, "R3 unit stride", 0);
    run_op(3, 16, 8, "R4 same bank", 0);
    run_op(0, 32, 6, "R4 stride 32", 0);
    run_op(100, 2, 20, "R3 stride 2", 0);
    run_op(40, 8, 12, "R4 two banks", 0);
    run_op(5, -1, 10, "R2 negative stride", 0);
    run_op(1020, 3, 10, "R2 top wrap", 0);
    run_op(9, 1, 0, "R7 zero length", 0);
    run_op(77, 33, 1, "R6 single element", 0);
    run_op(0, 5, 100, "R11 clamp", 0);
    run_op(200, 4, 16, "R8 start ignored", 5);
    fill_word(37, 64'h0123_4567_89AB_CDEF);
    fill_word(54, 64'hFEED_FACE_0000_1111);
    run_op(37, 17, 2, "R9 fill update", 0);

    repeat (20) @(negedge clk);
    summary();
    $finish;
  end
endmodule